// File: doc/BRIEF.md
# Host Bus Width Adapter Bridge

This block connects a parallel host bus to a byte-wide internal register core. The host bus runs at either 8 or 16 bits, chosen by a static select input. The core has a 7-bit byte address, an 8-bit write data path, an 8-bit read data path, and separate one-cycle read and write strobes. In 8-bit mode each host access becomes one core access, and the address and data pass through unchanged. In 16-bit mode each host access becomes two core byte accesses, made on consecutive cycles. The even byte address always goes first.

A static endianness input decides which half of the 16-bit host word belongs to the even core address. A host freeze line passes straight through to the core freeze line. The host holds it high while it reads a multi-byte value in pieces, so the value stays consistent. The bridge accepts one request, made as a one-cycle `host_rd` or `host_wr` pulse, and then sequences it. It pulses `host_done` when every byte access of that request has finished.

The sequencer is a state machine with six states:
- IDLE: waits for a request.
- LO: even-byte access.
- HI: odd-byte access.
- ONE: single access in 8-bit mode.
- TAIL: captures the last returned read byte.
- FIN: done cycle.

The transitions are:
- IDLE→LO on a request in 16-bit mode.
- IDLE→ONE on a request in 8-bit mode.
- LO→HI always.
- HI→FIN for a write, HI→TAIL for a read.
- ONE→FIN for a write, ONE→TAIL for a read.
- TAIL→FIN always.
- FIN→IDLE always.

The core returns read data one cycle after its read strobe.

Top module: `hbw_bridge`

## Requirements
- R1: With `cfg_narrow`=1, a host write gives exactly one core write strobe. The strobe carries `host_addr` unchanged and `host_wdata[7:0]`. `host_done` is high in the 2nd cycle after the request cycle.
- R2: With `cfg_narrow`=1, a host read gives exactly one core read strobe at `host_addr`. `host_rdata` is {8'h00, returned byte}. `host_done` is high in the 3rd cycle after the request cycle.
- R3: With `cfg_narrow`=0, a host write gives two core write strobes on consecutive cycles. The first is at the even address {`host_addr[6:1]`,0} and the second at the odd address {`host_addr[6:1]`,1}.
- R4: For 16-bit writes with `cfg_big`=0, `host_wdata[7:0]` goes to the even address and `host_wdata[15:8]` to the odd address. With `cfg_big`=1 the lanes are swapped.
- R5: With `cfg_narrow`=0, a host read gives two core read strobes on consecutive cycles, even address first. `host_done` is high in the 4th cycle after the request cycle.
- R6: For 16-bit reads, `host_rdata` is {odd byte, even byte} when `cfg_big`=0 and {even byte, odd byte} when `cfg_big`=1. It is valid while `host_done` is high.
- R7: `host_done` lasts exactly one cycle. No core strobe is active while it is high, and the core read and write strobes are never active together.
- R8: While a request is in progress, further host requests are ignored. If `host_rd` and `host_wr` are high together, the request is a write.
- R9: `core_frz` follows `host_frz` in the same cycle, in either width mode.
- R10: After reset there are no core strobes, `host_done` is low and `host_rdata` is zero.
- R11: With `cfg_narrow`=0, `host_done` for a write is high in the 3rd cycle after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_narrow | input | 1 | Host width: 0 = 16 bit, 1 = 8 bit (static) |
| cfg_big | input | 1 | Byte order: 1 = even byte in upper half (static) |
| host_frz | input | 1 | Host freeze request |
| host_rd | input | 1 | One-cycle host read request |
| host_wr | input | 1 | One-cycle host write request |
| host_addr | input | 7 | Host byte address (bit 0 ignored in 16-bit mode) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Assembled read data |
| host_done | output | 1 | One-cycle completion pulse |
| core_frz | output | 1 | Freeze line to the core |
| core_rd | output | 1 | Core read strobe |
| core_wr | output | 1 | Core write strobe |
| core_addr | output | 7 | Core byte address |
| core_wdata | output | 8 | Core write byte |
| core_rdata | input | 8 | Core read byte, valid one cycle after `core_rd` |

## Verification
On every cycle, the assertions check the following:
- The read and write strobes are never active together.
- The done pulse lasts one cycle.
- In 16-bit mode, an even-address strobe is followed by the odd-address strobe of the same word.
- In 8-bit mode, a strobe is never followed by a second one.

Only the bench scenarios can show the rest. These are the byte-lane placement for each endianness, the assembled read word, the exact done latency, that requests made while busy are dropped, and that a write wins over a simultaneous read. The bench shows these by comparing core traffic and host results with a shadow model of the register contents.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_ONE,
        ST_TAIL,
        ST_FIN
    } hbw_state_e;
endpackage

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
    import hbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_rd,
    input  logic host_wr,
    input  logic cfg_narrow,
    output logic accept,
    output logic is_wr,
    output logic wide,
    output logic strb,
    output logic use_lsb,
    output logic lsb,
    output logic cap_lo,
    output logic cap_last,
    output logic done
);
    hbw_state_e st, st_nx;
    logic       is_wr_q, wide_q;

    assign accept = (st == ST_IDLE) && (host_rd || host_wr);
    assign is_wr  = is_wr_q;
    assign wide   = wide_q;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (host_rd || host_wr) st_nx = cfg_narrow ? ST_ONE : ST_LO;
            ST_LO:   st_nx = ST_HI;
            ST_HI:   st_nx = is_wr_q ? ST_FIN : ST_TAIL;
            ST_ONE:  st_nx = is_wr_q ? ST_FIN : ST_TAIL;
            ST_TAIL: st_nx = ST_FIN;
            ST_FIN:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and request attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            is_wr_q <= 1'b0;
            wide_q  <= 1'b0;
        end else begin
            st <= st_nx;
            if (accept) begin
                is_wr_q <= host_wr;
                wide_q  <= !cfg_narrow;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        strb     = 1'b0;
        use_lsb  = 1'b0;
        lsb      = 1'b0;
        cap_lo   = 1'b0;
        cap_last = 1'b0;
        done     = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_LO: begin
                strb    = 1'b1;
                use_lsb = 1'b1;
            end
            ST_HI: begin
                strb    = 1'b1;
                use_lsb = 1'b1;
                lsb     = 1'b1;
                cap_lo  = !is_wr_q;
            end
            ST_ONE:  strb     = 1'b1;
            ST_TAIL: cap_last = 1'b1;
            ST_FIN:  done     = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hbw_lanes.sv
module hbw_lanes #(
    parameter int AW  = 7,
    parameter int CDW = 8,
    localparam int HDW = 2 * CDW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           cfg_big,
    input  logic [AW-1:0]  host_addr,
    input  logic [HDW-1:0] host_wdata,
    input  logic           wide,
    input  logic           use_lsb,
    input  logic           lsb,
    input  logic           cap_lo,
    input  logic           cap_last,
    input  logic [CDW-1:0] core_rdata,
    output logic [AW-1:0]  core_addr,
    output logic [CDW-1:0] core_wdata,
    output logic [HDW-1:0] host_rdata
);
    logic [AW-1:0]  addr_q;
    logic [HDW-1:0] wdata_q;
    logic           big_q;
    logic [CDW-1:0] even_q;
    logic [HDW-1:0] rdata_q;
    logic [CDW-1:0] even_byte, odd_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            big_q   <= 1'b0;
            even_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
                big_q   <= cfg_big;
            end
            if (cap_lo) even_q <= core_rdata;
            if (cap_last) begin
                if (!wide)      rdata_q <= {{CDW{1'b0}}, core_rdata};
                else if (big_q) rdata_q <= {even_q, core_rdata};
                else            rdata_q <= {core_rdata, even_q};
            end
        end
    end

    assign even_byte = big_q ? wdata_q[HDW-1:CDW] : wdata_q[CDW-1:0];
    assign odd_byte  = big_q ? wdata_q[CDW-1:0]   : wdata_q[HDW-1:CDW];

    always_comb begin
        if (use_lsb) begin
            core_addr  = {addr_q[AW-1:1], lsb};
            core_wdata = lsb ? odd_byte : even_byte;
        end else begin
            core_addr  = addr_q;
            core_wdata = wdata_q[CDW-1:0];
        end
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/hbw_bridge.sv
module hbw_bridge #(
    parameter int AW  = 7,
    parameter int CDW = 8,
    localparam int HDW = 2 * CDW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_narrow,
    input  logic           cfg_big,
    input  logic           host_frz,
    input  logic           host_rd,
    input  logic           host_wr,
    input  logic [AW-1:0]  host_addr,
    input  logic [HDW-1:0] host_wdata,
    output logic [HDW-1:0] host_rdata,
    output logic           host_done,
    output logic           core_frz,
    output logic           core_rd,
    output logic           core_wr,
    output logic [AW-1:0]  core_addr,
    output logic [CDW-1:0] core_wdata,
    input  logic [CDW-1:0] core_rdata
);
    logic accept, is_wr, wide, strb, use_lsb, lsb, cap_lo, cap_last;

    hbw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .cfg_narrow(cfg_narrow),
        .accept    (accept),
        .is_wr     (is_wr),
        .wide      (wide),
        .strb      (strb),
        .use_lsb   (use_lsb),
        .lsb       (lsb),
        .cap_lo    (cap_lo),
        .cap_last  (cap_last),
        .done      (host_done)
    );

    hbw_lanes #(.AW(AW), .CDW(CDW)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cfg_big   (cfg_big),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .wide      (wide),
        .use_lsb   (use_lsb),
        .lsb       (lsb),
        .cap_lo    (cap_lo),
        .cap_last  (cap_last),
        .core_rdata(core_rdata),
        .core_addr (core_addr),
        .core_wdata(core_wdata),
        .host_rdata(host_rdata)
    );

    assign core_rd  = strb && !is_wr;
    assign core_wr  = strb && is_wr;
    assign core_frz = host_frz;
endmodule

// File: rtl/hbw_chk.sv
module hbw_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_narrow,
    input logic          host_done,
    input logic          core_rd,
    input logic          core_wr,
    input logic [AW-1:0] core_addr
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rd && core_wr)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> !(core_rd || core_wr)); // R7
    AST_WR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_narrow && core_wr && !core_addr[0]) |=>
        (core_wr && core_addr[0] && core_addr[AW-1:1] == $past(core_addr[AW-1:1]))); // R3
    AST_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_narrow && core_rd && !core_addr[0]) |=>
        (core_rd && core_addr[0] && core_addr[AW-1:1] == $past(core_addr[AW-1:1]))); // R5
    AST_NARROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_narrow && (core_rd || core_wr)) |=> !(core_rd || core_wr)); // R1
endmodule

bind hbw_bridge hbw_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_narrow(cfg_narrow),
    .host_done (host_done),
    .core_rd   (core_rd),
    .core_wr   (core_wr),
    .core_addr (core_addr)
);

// File: tb/sim_hbw_bridge.sv
module sim_hbw_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_narrow = 1'b0, cfg_big = 1'b0, host_frz = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_done, core_frz, core_rd, core_wr;
    logic [6:0]  core_addr;
    logic [7:0]  core_wdata;
    logic [7:0]  core_q = '0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem [128];
    logic [7:0] shd [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbw_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_big(cfg_big),
        .host_frz(host_frz), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .core_frz(core_frz), .core_rd(core_rd),
        .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_q)
    );

    // core model: write on strobe, read data one cycle after strobe
    always @(posedge clk) begin
        if (core_wr) mem[core_addr] <= core_wdata;
        if (core_rd) core_q <= mem[core_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // observed traffic of the last operation
    int         lg_n, lg_lat, lg_nwr, lg_nrd;
    logic [6:0] lg_a [4];
    logic [7:0] lg_d [4];
    logic [15:0] lg_rd_val;

    task automatic run_op(input bit wr, input bit both, input logic [6:0] a,
                          input logic [15:0] d, input bit busy_poke);
        @(negedge clk);
        host_wr = wr || both; host_rd = !wr || both;
        host_addr = a; host_wdata = d;
        lg_n = 0; lg_lat = 0; lg_nwr = 0; lg_nrd = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            host_wr = 1'b0; host_rd = 1'b0;
            if (busy_poke && i == 0) begin
                host_wr = 1'b1; host_addr = a ^ 7'h22; host_wdata = ~d;
            end
            lg_lat++;
            if (core_wr || core_rd) begin
                if (lg_n < 4) begin
                    lg_a[lg_n] = core_addr; lg_d[lg_n] = core_wdata;
                end
                lg_n++;
                if (core_wr) lg_nwr++;
                if (core_rd) lg_nrd++;
            end
            if (host_done) begin
                lg_rd_val = host_rdata;
                break;
            end
        end
        // a few idle cycles: nothing more may happen
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (core_wr || core_rd) lg_n++;
        end
    endtask

    task automatic check_op(input bit wr, input logic [6:0] a, input logic [15:0] d, input string tag);
        logic [6:0] ev;
        logic [7:0] b0, b1;
        logic [15:0] exp;
        ev = {a[6:1], 1'b0};
        if (cfg_narrow) begin
            chk(lg_n == 1, wr ? "R1 strobe count" : "R2 strobe count", lg_n, 1);
            chk(lg_a[0] == a, wr ? "R1 addr" : "R2 addr", lg_a[0], a);
            if (wr) begin
                chk(lg_nwr == 1, "R1 write kind", lg_nwr, 1);
                chk(lg_d[0] == d[7:0], "R1 data", lg_d[0], d[7:0]);
                chk(lg_lat == 2, "R1 latency", lg_lat, 2);
                shd[a] = d[7:0];
            end else begin
                chk(lg_nrd == 1, "R2 read kind", lg_nrd, 1);
                chk(lg_lat == 3, "R2 latency", lg_lat, 3);
                exp = {8'h00, shd[a]};
                chk(lg_rd_val == exp, "R2 read value", lg_rd_val, exp);
            end
        end else begin
            chk(lg_n == 2, wr ? "R3 strobe count" : "R5 strobe count", lg_n, 2);
            chk(lg_a[0] == ev && lg_a[1] == (ev | 7'd1), wr ? "R3 addr order" : "R5 addr order",
                {lg_a[0], lg_a[1]}, {ev, ev | 7'd1});
            if (wr) begin
                b0 = cfg_big ? d[15:8] : d[7:0];
                b1 = cfg_big ? d[7:0] : d[15:8];
                chk(lg_nwr == 2, "R3 write kind", lg_nwr, 2);
                chk(lg_d[0] == b0 && lg_d[1] == b1, "R4 lanes", {lg_d[0], lg_d[1]}, {b0, b1});
                chk(lg_lat == 3, "R11 latency", lg_lat, 3);
                shd[ev] = b0; shd[ev | 7'd1] = b1;
            end else begin
                chk(lg_nrd == 2, "R5 read kind", lg_nrd, 2);
                chk(lg_lat == 4, "R5 latency", lg_lat, 4);
                exp = cfg_big ? {shd[ev], shd[ev | 7'd1]} : {shd[ev | 7'd1], shd[ev]};
                chk(lg_rd_val == exp, "R6 read value", lg_rd_val, exp);
            end
        end
        if (n_fail != 0 && tag.len() == 0) ;
    endtask

    task automatic op(input bit wr, input logic [6:0] a, input logic [15:0] d);
        run_op(wr, 1'b0, a, d, 1'b0);
        check_op(wr, a, d, "");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i] = 8'(i * 7 + 3);
            shd[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!core_wr && !core_rd && !host_done, "R10 strobes in reset", {core_wr, core_rd, host_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_rdata == 16'h0, "R10 rdata after reset", host_rdata, 0);
        chk(!core_wr && !core_rd && !host_done, "R10 idle after reset", {core_wr, core_rd, host_done}, 0);

        // R9: freeze passthrough in both modes
        for (int m = 0; m < 2; m++) begin
            cfg_narrow = m[0];
            host_frz = 1'b1; #1;
            chk(core_frz == 1'b1, "R9 freeze high", core_frz, 1);
            host_frz = 1'b0; #1;
            chk(core_frz == 1'b0, "R9 freeze low", core_frz, 0);
        end

        // directed corner cases
        cfg_narrow = 1'b0; cfg_big = 1'b0;
        op(1'b1, 7'h11, 16'hA1B2);      // odd host address, little endian
        op(1'b0, 7'h10, 16'h0);
        cfg_big = 1'b1;
        op(1'b1, 7'h7F, 16'hC3D4);      // top word, big endian
        op(1'b0, 7'h7E, 16'h0);
        cfg_narrow = 1'b1;
        op(1'b1, 7'h7F, 16'hEE5A);
        op(1'b0, 7'h7F, 16'h0);

        // R8: request while busy is dropped
        cfg_narrow = 1'b0; cfg_big = 1'b0;
        run_op(1'b1, 1'b0, 7'h04, 16'h1357, 1'b1);
        check_op(1'b1, 7'h04, 16'h1357, "");
        chk(lg_n == 2, "R8 busy request ignored", lg_n, 2);
        op(1'b0, 7'h04 ^ 7'h22, 16'h0); // untouched word still holds old value

        // R8: read and write together act as a write
        cfg_narrow = 1'b1;
        run_op(1'b1, 1'b1, 7'h30, 16'h0099, 1'b0);
        chk(lg_nwr == 1 && lg_nrd == 0, "R8 write wins", {lg_nwr, lg_nrd}, 1 << 32);
        chk(mem[7'h30] == 8'h99, "R8 write wins data", mem[7'h30], 8'h99);
        shd[7'h30] = 8'h99;

        // R7 observed: done lasts one cycle
        cfg_narrow = 1'b0;
        run_op(1'b0, 1'b0, 7'h20, 16'h0, 1'b0);
        chk(!host_done, "R7 done single cycle", host_done, 0);

        // constrained random mix
        void'($urandom(32'd4242));
        for (int k = 0; k < 80; k++) begin
            logic        w;
            logic [6:0]  a;
            logic [15:0] d;
            cfg_narrow = $urandom % 2;
            cfg_big    = $urandom % 2;
            w = $urandom % 2;
            a = 7'($urandom);
            d = 16'($urandom);
            op(w, a, d);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=1 exp=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule